// File: doc/BRIEF.md
# AUX-to-I2C Transaction Bridge

This block takes display-link auxiliary-channel requests, one at a time, and carries each one out against one of two targets. Every request brings a command, a 20-bit address, a byte count and up to sixteen bytes of write data. Native reads and writes are sent byte by byte to a register port that covers a 1 MiB address space. I2C-over-AUX commands become a sequence of primitive operations on an abstract I2C master: start, send a byte, receive a byte and stop.

The block returns a 2-bit reply code and, for reads, the collected bytes. It also remembers whether the I2C side is still open. This lets middle-of-transaction (MOT) requests keep the bus held from one request to the next. A held bus is torn down and restarted only when the target address or the transfer direction changes. Plain (non-MOT) I2C requests always leave the bus closed when they finish.

Top module: `aux_i2c_bridge`

## Requirements
- R1: After reset the bridge is idle. `req_ready` is 1, `rsp_valid` is 0, no register or I2C operation is requested, and the I2C side is considered closed.
- R2: Native write (command 0) and native read (command 1) access one byte per register-port cycle. The first access is at the request address, and the address rises by one per byte, wrapping within 20 bits. When every byte is accepted, the reply is ACK (code 00).
- R3: A native access ends at the first byte the register port rejects (`reg_ok` low) and replies NACK (code 01). No later byte of that request is presented.
- R4: A plain I2C write (command 2) or read (command 3) first stops any open I2C transaction. It then starts to `addr[6:0]` in the matching direction, moves all bytes, issues a stop and replies I2C_ACK (code 11). I2C operation codes are: start-write 1, start-read 2, send 3, receive 4, stop 5.
- R5: If the target does not acknowledge a start, the reply is I2C_NACK (code 10), no data byte is moved, no stop follows, and the I2C side is closed.
- R6: In a plain I2C write, the first byte the target rejects ends the transfer. A stop is still issued, and the reply is I2C_NACK.
- R7: An MOT write (command 4) or MOT read (command 5) issues a start only in three cases: the bus is closed, the address differs from the last recorded MOT address, or the command differs from the last recorded MOT command. When the bus is open and a restart is needed, a stop comes before the start.
- R8: Once an MOT start is acknowledged, the block records that request's address and command. An MOT request that completes leaves the bus open and replies I2C_ACK, so a following MOT request with the same address and command sends or receives data with no start.
- R9: If any byte of an MOT write is rejected, the block issues a stop, closes the bus and replies I2C_NACK.
- R10: Commands 6 and 7, and lengths of 0 or above 16, get a NACK reply with no register or I2C activity.
- R11: `req_ready` stays low from acceptance until the reply has been taken. `rsp_valid`, `rsp_code` and `rsp_rdata` hold steady while `rsp_ready` is low.
- R12: Read byte i (counting from 0) of a successful read is returned in `rsp_rdata[8*i +: 8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge can accept a request |
| req_cmd | input | 3 | Command code |
| req_addr | input | 20 | Register address or I2C target address (low 7 bits) |
| req_len | input | 5 | Byte count, 1 to 16 |
| req_wdata | input | 128 | Write bytes, byte i at bits 8i+7:8i |
| rsp_valid | output | 1 | Reply present |
| rsp_ready | input | 1 | Reply taken |
| rsp_code | output | 2 | Reply code |
| rsp_rdata | output | 128 | Read bytes |
| reg_en | output | 1 | Register-port byte access |
| reg_we | output | 1 | Register-port write |
| reg_addr | output | 20 | Register-port byte address |
| reg_wdata | output | 8 | Register-port write byte |
| reg_ok | input | 1 | Register port accepts this cycle's access |
| reg_rdata | input | 8 | Register-port read byte |
| i2c_valid | output | 1 | I2C operation requested |
| i2c_op | output | 3 | I2C operation code |
| i2c_addr | output | 7 | I2C target address for starts |
| i2c_wdata | output | 8 | Byte to send |
| i2c_ready | input | 1 | I2C operation completes this cycle |
| i2c_ack | input | 1 | Target acknowledged the start or the sent byte |
| i2c_rdata | input | 8 | Received byte |

## Verification
The bench mixes MOT requests over a small set of target addresses, so continuation, address change and direction change all come up often. A bridge that compared only the address would skip the restart when the direction flips, and one that forgot the open state would send a needless start. Native accesses are aimed across the start of a rejecting address region and across the 20-bit wrap point. An address counter that did not stop on the first rejection would show an extra access, and one that did not wrap would access the wrong byte. Start refusals and rejected write bytes are injected to check where stops appear: after a rejected plain or MOT write byte, but never after a refused start.

// File: rtl/aux_bridge_pkg.sv
package aux_bridge_pkg;

    // command codes; bit 0 marks a read, bit 2 marks the MOT forms
    localparam logic [2:0] CMD_NAT_WR = 3'd0;
    localparam logic [2:0] CMD_NAT_RD = 3'd1;
    localparam logic [2:0] CMD_I2C_WR = 3'd2;
    localparam logic [2:0] CMD_I2C_RD = 3'd3;
    localparam logic [2:0] CMD_MOT_WR = 3'd4;
    localparam logic [2:0] CMD_MOT_RD = 3'd5;

    // reply codes
    localparam logic [1:0] RSP_ACK      = 2'b00;
    localparam logic [1:0] RSP_NACK     = 2'b01;
    localparam logic [1:0] RSP_I2C_NACK = 2'b10;
    localparam logic [1:0] RSP_I2C_ACK  = 2'b11;

    // I2C primitive operations
    localparam logic [2:0] OP_IDLE     = 3'd0;
    localparam logic [2:0] OP_START_WR = 3'd1;
    localparam logic [2:0] OP_START_RD = 3'd2;
    localparam logic [2:0] OP_SEND     = 3'd3;
    localparam logic [2:0] OP_RECV     = 3'd4;
    localparam logic [2:0] OP_STOP     = 3'd5;

    typedef enum logic [1:0] {CL_NATIVE, CL_PLAIN, CL_MOT, CL_BAD} cls_t;

    typedef enum logic [2:0] {
        S_IDLE, S_NAT, S_PRESTOP, S_START, S_XFER, S_POSTSTOP, S_RESP
    } st_t;

endpackage

// File: rtl/aux_cmd_class.sv
module aux_cmd_class
    import aux_bridge_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic [2:0]       cmd,
    input  logic [LEN_W-1:0] len,
    output cls_t             cls
);
    logic len_ok;

    always_comb begin
        len_ok = (len != '0) && (len <= LEN_W'(MAX_LEN));
        unique case (cmd)
            CMD_NAT_WR, CMD_NAT_RD: cls = CL_NATIVE;
            CMD_I2C_WR, CMD_I2C_RD: cls = CL_PLAIN;
            CMD_MOT_WR, CMD_MOT_RD: cls = CL_MOT;
            default:                cls = CL_BAD;
        endcase
        if (!len_ok) cls = CL_BAD;
    end
endmodule

// File: rtl/aux_mot_track.sv
module aux_mot_track #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_set,
    input  logic              open_clr,
    input  logic              rec_en,
    input  logic [ADDR_W-1:0] rec_addr,
    input  logic [2:0]        rec_cmd,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [2:0]        cmp_cmd,
    output logic              bus_open,
    output logic              restart
);
    typedef struct packed {
        logic              open;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        cmd;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (open_clr) trk_d.open = 1'b0;
        if (open_set) trk_d.open = 1'b1;
        if (rec_en) begin
            trk_d.addr = rec_addr;
            trk_d.cmd  = rec_cmd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign bus_open = trk_q.open;
    assign restart  = !trk_q.open || (cmp_addr != trk_q.addr) || (cmp_cmd != trk_q.cmd);

    AST_OPEN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_set && open_clr)); // R7
    AST_REC_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        rec_en |=> bus_open && !restart || !$stable(cmp_addr) || !$stable(cmp_cmd) || cmp_addr != $past(rec_addr) || cmp_cmd != $past(rec_cmd)); // R8
endmodule

// File: rtl/aux_i2c_bridge.sv
module aux_i2c_bridge
    import aux_bridge_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int MAX_LEN  = 16,
    parameter int I2C_AW   = 7,
    parameter int LEN_W    = $clog2(MAX_LEN + 1),
    parameter int BUF_W    = MAX_LEN * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [BUF_W-1:0]  req_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_code,
    output logic [BUF_W-1:0]  rsp_rdata,
    output logic              reg_en,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    input  logic              reg_ok,
    input  logic [7:0]        reg_rdata,
    output logic              i2c_valid,
    output logic [2:0]        i2c_op,
    output logic [I2C_AW-1:0] i2c_addr,
    output logic [7:0]        i2c_wdata,
    input  logic              i2c_ready,
    input  logic              i2c_ack,
    input  logic [7:0]        i2c_rdata
);
    typedef struct packed {
        st_t               st;
        logic [2:0]        cmd;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  idx;
        logic [BUF_W-1:0]  wbuf;
        logic [BUF_W-1:0]  rbuf;
        logic [1:0]        code;
    } brg_t;

    brg_t r_d, r_q;
    cls_t cls;
    logic bus_open, restart;
    logic open_set, open_clr, rec_en;
    logic rd_q, mot_q, last_q;

    aux_cmd_class #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_class (
        .cmd (req_cmd),
        .len (req_len),
        .cls (cls)
    );

    aux_mot_track #(.ADDR_W(ADDR_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_set (open_set),
        .open_clr (open_clr),
        .rec_en   (rec_en),
        .rec_addr (r_q.addr),
        .rec_cmd  (r_q.cmd),
        .cmp_addr (req_addr),
        .cmp_cmd  (req_cmd),
        .bus_open (bus_open),
        .restart  (restart)
    );

    assign rd_q   = r_q.cmd[0];
    assign mot_q  = r_q.cmd[2];
    assign last_q = (r_q.idx == r_q.len - 1'b1);

    always_comb begin
        r_d       = r_q;
        reg_en    = 1'b0;
        i2c_valid = 1'b0;
        i2c_op    = OP_IDLE;
        open_set  = 1'b0;
        open_clr  = 1'b0;
        rec_en    = 1'b0;
        unique case (r_q.st)
            S_IDLE: if (req_valid) begin
                r_d.cmd  = req_cmd;
                r_d.addr = req_addr;
                r_d.len  = req_len;
                r_d.wbuf = req_wdata;
                r_d.rbuf = '0;
                r_d.idx  = '0;
                unique case (cls)
                    CL_BAD:    begin r_d.code = RSP_NACK; r_d.st = S_RESP; end
                    CL_NATIVE: r_d.st = S_NAT;
                    CL_PLAIN:  r_d.st = bus_open ? S_PRESTOP : S_START;
                    default:   r_d.st = !restart ? S_XFER
                                      : (bus_open ? S_PRESTOP : S_START);
                endcase
            end
            S_NAT: begin
                reg_en = 1'b1;
                if (!reg_ok) begin
                    r_d.code = RSP_NACK;
                    r_d.st   = S_RESP;
                end else begin
                    if (rd_q) r_d.rbuf[r_q.idx*8 +: 8] = reg_rdata;
                    r_d.idx  = r_q.idx + 1'b1;
                    r_d.addr = r_q.addr + 1'b1;
                    if (last_q) begin
                        r_d.code = RSP_ACK;
                        r_d.st   = S_RESP;
                    end
                end
            end
            S_PRESTOP: begin
                i2c_valid = 1'b1;
                i2c_op    = OP_STOP;
                if (i2c_ready) begin
                    open_clr = 1'b1;
                    r_d.st   = S_START;
                end
            end
            S_START: begin
                i2c_valid = 1'b1;
                i2c_op    = rd_q ? OP_START_RD : OP_START_WR;
                if (i2c_ready) begin
                    if (i2c_ack) begin
                        open_set = 1'b1;
                        rec_en   = mot_q;
                        r_d.st   = S_XFER;
                    end else begin
                        open_clr = 1'b1;
                        r_d.code = RSP_I2C_NACK;
                        r_d.st   = S_RESP;
                    end
                end
            end
            S_XFER: begin
                i2c_valid = 1'b1;
                i2c_op    = rd_q ? OP_RECV : OP_SEND;
                if (i2c_ready) begin
                    if (!rd_q && !i2c_ack) begin
                        r_d.code = RSP_I2C_NACK;
                        r_d.st   = S_POSTSTOP;
                    end else begin
                        if (rd_q) r_d.rbuf[r_q.idx*8 +: 8] = i2c_rdata;
                        r_d.idx = r_q.idx + 1'b1;
                        if (last_q) begin
                            r_d.code = RSP_I2C_ACK;
                            r_d.st   = mot_q ? S_RESP : S_POSTSTOP;
                        end
                    end
                end
            end
            S_POSTSTOP: begin
                i2c_valid = 1'b1;
                i2c_op    = OP_STOP;
                if (i2c_ready) begin
                    open_clr = 1'b1;
                    r_d.st   = S_RESP;
                end
            end
            default: if (rsp_ready) r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == S_IDLE);
    assign rsp_valid = (r_q.st == S_RESP);
    assign rsp_code  = r_q.code;
    assign rsp_rdata = r_q.rbuf;
    assign reg_we    = !rd_q;
    assign reg_addr  = r_q.addr;
    assign reg_wdata = r_q.wbuf[r_q.idx*8 +: 8];
    assign i2c_addr  = r_q.addr[I2C_AW-1:0];
    assign i2c_wdata = r_q.wbuf[r_q.idx*8 +: 8];

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> req_ready); // R1
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code) && $stable(rsp_rdata)); // R11
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R11
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en && i2c_valid)); // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_en && reg_ok |=> !reg_en || reg_addr == $past(reg_addr) + 1'b1); // R2
    AST_REJECT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_en && !reg_ok |=> !reg_en && rsp_valid && rsp_code == RSP_NACK); // R3
    AST_STOP_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_valid && i2c_op == OP_STOP |-> bus_open); // R4
    AST_START_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_valid && (i2c_op == OP_START_WR || i2c_op == OP_START_RD) |-> !bus_open); // R7
    AST_DATA_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_valid && (i2c_op == OP_SEND || i2c_op == OP_RECV) |-> bus_open); // R8
    AST_REFUSED_START: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_valid && i2c_ready && !i2c_ack && (i2c_op == OP_START_WR || i2c_op == OP_START_RD)
        |=> rsp_valid && rsp_code == RSP_I2C_NACK && !bus_open); // R5
    AST_BAD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready && req_valid && cls == CL_BAD |=> rsp_valid && rsp_code == RSP_NACK); // R10
endmodule

// File: tb/aux_i2c_bridge_tb_top.sv
module aux_i2c_bridge_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [2:0]   req_cmd = '0;
    logic [19:0]  req_addr = '0;
    logic [4:0]   req_len = '0;
    logic [127:0] req_wdata = '0;
    logic         rsp_valid;
    logic         rsp_ready = 1'b0;
    logic [1:0]   rsp_code;
    logic [127:0] rsp_rdata;
    logic         reg_en, reg_we, reg_ok;
    logic [19:0]  reg_addr;
    logic [7:0]   reg_wdata, reg_rdata;
    logic         i2c_valid, i2c_ready, i2c_ack;
    logic [2:0]   i2c_op;
    logic [6:0]   i2c_addr;
    logic [7:0]   i2c_wdata, i2c_rdata;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    aux_i2c_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
        .rsp_rdata(rsp_rdata),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ok(reg_ok), .reg_rdata(reg_rdata),
        .i2c_valid(i2c_valid), .i2c_op(i2c_op), .i2c_addr(i2c_addr),
        .i2c_wdata(i2c_wdata), .i2c_ready(i2c_ready), .i2c_ack(i2c_ack),
        .i2c_rdata(i2c_rdata)
    );

    // ---------------- target models ----------------
    logic [7:0] mem [256];
    logic [7:0] rctr = 8'h00;
    logic       rdy_r = 1'b1;
    int         ev_log [$];

    function automatic bit reg_accepts(logic [19:0] a);
        return a[19:16] != 4'h8;
    endfunction
    function automatic bit start_acked(logic [6:0] a);
        return a[6:3] != 4'hF;
    endfunction
    function automatic bit byte_acked(logic [7:0] d);
        return d != 8'hEE;
    endfunction
    function automatic int ev(int op, int payload);
        return (op << 20) | payload;
    endfunction

    assign reg_ok    = reg_accepts(reg_addr);
    assign reg_rdata = mem[reg_addr[7:0]];
    assign i2c_ready = rdy_r;
    assign i2c_rdata = rctr;
    assign i2c_ack   = (i2c_op == 3'd1 || i2c_op == 3'd2) ? start_acked(i2c_addr)
                     : (i2c_op == 3'd3) ? byte_acked(i2c_wdata) : 1'b1;

    always @(negedge clk) rdy_r <= ($urandom % 4) != 0;

    always @(posedge clk) begin
        if (rst_n && reg_en) begin
            ev_log.push_back(ev(reg_we ? 9 : 8, int'(reg_addr)));
            if (reg_we && reg_ok) mem[reg_addr[7:0]] <= reg_wdata;
        end
        if (rst_n && i2c_valid && i2c_ready) begin
            case (i2c_op)
                3'd1, 3'd2: ev_log.push_back(ev(int'(i2c_op), int'(i2c_addr)));
                3'd3:       ev_log.push_back(ev(3, int'(i2c_wdata)));
                3'd4: begin ev_log.push_back(ev(4, int'(rctr))); rctr <= rctr + 8'd1; end
                default:    ev_log.push_back(ev(int'(i2c_op), 0));
            endcase
        end
    end

    // ---------------- reference model ----------------
    logic        m_open = 1'b0;
    logic [19:0] m_addr = '0;
    logic [2:0]  m_cmd  = '0;
    logic [7:0]  m_rctr = 8'h00;
    logic [7:0]  shadow [256];
    int          exp_ev [$];
    logic [1:0]  exp_code;
    logic [127:0] exp_rdata;
    string       exp_tag;

    task automatic predict(input logic [2:0] cmd, input logic [19:0] addr,
                           input int len, input logic [127:0] wd);
        bit rd = cmd[0];
        exp_ev.delete();
        exp_rdata = '0;
        if (cmd > 3'd5 || len < 1 || len > 16) begin
            exp_code = 2'b01; exp_tag = "R10";
        end else if (cmd <= 3'd1) begin
            exp_code = 2'b00; exp_tag = "R2";
            for (int i = 0; i < len; i++) begin
                logic [19:0] a = addr + 20'(i);
                exp_ev.push_back(ev(rd ? 8 : 9, int'(a)));
                if (!reg_accepts(a)) begin exp_code = 2'b01; exp_tag = "R3"; break; end
                if (rd) exp_rdata[i*8 +: 8] = shadow[a[7:0]];
                else    shadow[a[7:0]] = wd[i*8 +: 8];
            end
        end else begin
            bit mot = cmd[2];
            bit need = !mot || !m_open || addr != m_addr || cmd != m_cmd;
            exp_tag = mot ? "R7" : "R4";
            exp_code = 2'b11;
            if (need) begin
                if (m_open) exp_ev.push_back(ev(5, 0));
                m_open = 1'b0;
                exp_ev.push_back(ev(rd ? 2 : 1, int'(addr[6:0])));
                if (!start_acked(addr[6:0])) begin
                    exp_code = 2'b10; exp_tag = "R5";
                    return;
                end
                m_open = 1'b1;
                if (mot) begin m_addr = addr; m_cmd = cmd; end
            end else exp_tag = "R8";
            for (int i = 0; i < len; i++) begin
                if (rd) begin
                    exp_ev.push_back(ev(4, int'(m_rctr)));
                    exp_rdata[i*8 +: 8] = m_rctr;
                    m_rctr = m_rctr + 8'd1;
                end else begin
                    exp_ev.push_back(ev(3, int'(wd[i*8 +: 8])));
                    if (!byte_acked(wd[i*8 +: 8])) begin
                        exp_code = 2'b10;
                        exp_tag = mot ? "R9" : "R6";
                        if (mot) begin exp_ev.push_back(ev(5, 0)); m_open = 1'b0; end
                        break;
                    end
                end
            end
            if (!mot) begin exp_ev.push_back(ev(5, 0)); m_open = 1'b0; end
        end
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_req(input logic [2:0] cmd, input logic [19:0] addr,
                           input int len, input logic [127:0] wd);
        bit busy_ok = 1'b1;
        bit hold_ok = 1'b1;
        bit ev_ok;
        logic [1:0] got_code;
        logic [127:0] got_data;
        predict(cmd, addr, len, wd);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        ev_log.delete();
        req_cmd = cmd; req_addr = addr; req_len = 5'(len); req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
        end
        got_code = rsp_code;
        got_data = rsp_rdata;
        repeat ($urandom % 3) begin
            @(negedge clk);
            if (!rsp_valid || req_ready || rsp_code != got_code || rsp_rdata != got_data)
                hold_ok = 1'b0;
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        ev_ok = (ev_log.size() == exp_ev.size());
        if (ev_ok)
            foreach (exp_ev[i]) if (ev_log[i] != exp_ev[i]) ev_ok = 1'b0;
        chk(got_code == exp_code, exp_tag, "reply code", 128'(got_code), 128'(exp_code));
        chk(ev_ok, exp_tag, "bus activity", 128'(ev_log.size()), 128'(exp_ev.size()));
        chk(busy_ok && hold_ok, "R11", "handshake hold", 128'({busy_ok, hold_ok}), 128'(3));
        if (cmd[0] && cmd <= 3'd5 && (exp_code == 2'b00 || exp_code == 2'b11))
            chk(got_data == exp_rdata, "R12", "read data", got_data, exp_rdata);
    endtask

    function automatic logic [127:0] rand_data();
        logic [127:0] d;
        for (int i = 0; i < 16; i++)
            d[i*8 +: 8] = (($urandom % 24) == 0) ? 8'hEE : 8'($urandom);
        return d;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [6:0] i2c_pool [3];
        void'($urandom(32'h5eed_0017));
        i2c_pool[0] = 7'h50; i2c_pool[1] = 7'h51; i2c_pool[2] = 7'h7C;
        for (int i = 0; i < 256; i++) begin mem[i] = 8'(i); shadow[i] = 8'(i); end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !reg_en && !i2c_valid, "R1", "reset state",
            128'({req_ready, rsp_valid, reg_en, i2c_valid}), 128'(4'b1000));

        // directed corner cases
        run_req(3'd2, 20'h00050, 2, 128'h0000_1234);                  // R4 from closed bus
        run_req(3'd0, 20'h7FFFC, 8, rand_data());                      // R3 reject region
        run_req(3'd0, 20'hFFFFE, 4, 128'hA1B2C3D4);                    // R2 wrap
        run_req(3'd1, 20'hFFFFE, 4, '0);                               // R2 read back
        run_req(3'd4, 20'h00050, 3, 128'h112233);                      // R7 open
        run_req(3'd4, 20'h00050, 2, 128'h4455);                        // R8 continue
        run_req(3'd5, 20'h00050, 2, '0);                               // R7 direction change
        run_req(3'd5, 20'h00051, 3, '0);                               // R7 address change
        run_req(3'd5, 20'h00051, 1, '0);                               // R8 continue read
        run_req(3'd3, 20'h00051, 2, '0);                               // R4 closes open bus
        run_req(3'd4, 20'h0007C, 2, 128'h99);                          // R5 refused start
        run_req(3'd2, 20'h00050, 3, 128'h77EE66);                      // R6 rejected byte
        run_req(3'd4, 20'h00051, 3, 128'h00EE01);                      // R9 rejected byte
        run_req(3'd6, 20'h00050, 2, '0);                               // R10 bad command
        run_req(3'd7, 20'h00010, 2, '0);                               // R10 bad command
        run_req(3'd0, 20'h00010, 0, '0);                               // R10 zero length
        run_req(3'd3, 20'h00050, 17, '0);                              // R10 overlong
        run_req(3'd1, 20'h00020, 16, '0);                              // R12 full length

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int r = int'($urandom % 16);
            logic [2:0] c;
            logic [19:0] a;
            int l = 1 + int'($urandom % 16);
            if (($urandom % 20) == 0) l = (($urandom % 2) == 0) ? 0 : 17;
            if (r < 2)       c = 3'd0;
            else if (r < 4)  c = 3'd1;
            else if (r < 5)  c = 3'd2;
            else if (r < 6)  c = 3'd3;
            else if (r < 9)  c = 3'd4;
            else if (r < 12) c = 3'd5;
            else if (r < 13) c = 3'd6 + 3'($urandom % 2);
            else             c = 3'd4 + 3'($urandom % 2);
            if (c <= 3'd1) begin
                case ($urandom % 4)
                    0: a = 20'h7FFF4 + 20'($urandom % 16);
                    1: a = 20'hFFFF4 + 20'($urandom % 16);
                    default: a = 20'($urandom % 4096);
                endcase
            end else begin
                a = {13'd0, i2c_pool[(($urandom % 8) == 0) ? 2 : ($urandom % 2)]};
            end
            run_req(c, a, l, rand_data());
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule